// File: doc/BRIEF.md
# Sampled Switch Debouncer

This block turns a noisy, asynchronous switch signal into a clean level for synchronous logic. The raw input first passes through a two-register synchroniser. A free-running interval counter then produces one sample strobe every `SAMPLE_PERIOD` clock cycles. On each strobe the synchronised level is shifted into a history of the `RUN_LENGTH` most recent samples.

The debounced output moves to high only when every stored sample is high, and to low only when every stored sample is low. While the history holds a mix of levels, the output keeps its value. Sampling never stops, so any level that stays steady is eventually passed to the output.

With the default values (a strobe every 50,000 cycles and a run of eight samples) and a 50 MHz clock, samples are 1 ms apart. A settled change therefore reaches the output after roughly 8 ms.

Top module: `switch_debouncer`

## Requirements
- R1: The raw input reaches the sample history only through two register stages. After the raw input changes, the output cannot follow within fewer than (RUN_LENGTH-1)*SAMPLE_PERIOD cycles.
- R2: After reset is released, the sample strobe fires first on the SAMPLE_PERIOD-th clock edge and then on every SAMPLE_PERIOD-th edge after it. If the raw input is high during and after reset, the output rises on edge RUN_LENGTH*SAMPLE_PERIOD+1 after release and not earlier.
- R3: On each strobe the history shifts in exactly one synchronised sample and keeps the RUN_LENGTH most recent ones. Between strobes it does not change.
- R4: The output becomes 1 only when all RUN_LENGTH stored samples are 1. It becomes 0 only when all of them are 0.
- R5: While the history is mixed, the output holds its value. A level held for RUN_LENGTH-2 intervals or less never reaches the output, and neither does a pattern that keeps changing.
- R6: A level held steady for (RUN_LENGTH+1)*SAMPLE_PERIOD+3 cycles appears at the output.
- R7: The reset input `rst_n` is active-low and synchronous. When it is low at a clock edge, it clears the synchroniser, the interval counter, the history and the output, so the output reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | 1 | Asynchronous switch level |
| clean_out | output | 1 | Debounced level |

## Verification
A fault in the interval counter shows up as the output moving earlier or later than expected after a clean step. The step check after reset release pins this down to a single edge. A history that drops a sample, or shifts when it should not, lets short bursts through or delays steady levels, and this is visible within one burst of RUN_LENGTH-2 intervals. A fault in the hold rule for a mixed history makes the output chatter during a pattern that keeps changing, and this appears at the output within a few intervals.

// File: rtl/deb_pkg.sv
// Package: shared types for the switch debouncer.
// Assumes: nothing beyond the standard language.
package deb_pkg;
    // What the sample history says about the input level.
    typedef enum logic [1:0] {
        HIST_MIXED = 2'd0,
        HIST_LOW   = 2'd1,
        HIST_HIGH  = 2'd2
    } hist_state_e;

    // Width needed for a counter that runs from 0 to limit-1 (never less than 1).
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction
endpackage

// File: rtl/deb_sync.sv
// Module: deb_sync
// Passes an asynchronous level through a chain of STAGES registers.
// Assumes: STAGES >= 2; synchronous active-low reset clears every stage.
module deb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Purpose: load the chain, feeding the raw level into stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/deb_tick_gen.sv
// Module: deb_tick_gen
// Free-running interval counter that raises a one-cycle strobe every PERIOD cycles.
// Assumes: PERIOD >= 2; after reset the first strobe is seen on edge PERIOD.
module deb_tick_gen
    import deb_pkg::*;
#(
    parameter int unsigned PERIOD = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] count;

    // Purpose: advance the interval count and wrap it after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (count == LAST) count <= '0;
        else                    count <= count + 1'b1;
    end

    assign tick = (count == LAST);
endmodule

// File: rtl/deb_history.sv
// Module: deb_history
// Shift register of the DEPTH most recent strobed samples, plus an agreement summary.
// Assumes: DEPTH >= 2; reset fills the history with zeros (an all-low summary).
module deb_history
    import deb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sample,
    output logic [DEPTH-1:0] hist,
    output hist_state_e      state
);
    // Purpose: shift one sample in on each strobe, hold the history otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    hist <= '0;
        else if (tick) hist <= {hist[DEPTH-2:0], sample};
    end

    // Purpose: classify the history as all high, all low or mixed.
    always_comb begin
        if (&hist)       state = HIST_HIGH;
        else if (~|hist) state = HIST_LOW;
        else             state = HIST_MIXED;
    end
endmodule

// File: rtl/switch_debouncer.sv
// Module: switch_debouncer
// Debounces one switch: two-register synchroniser, periodic sampling, and an
// output that follows only a unanimous history of RUN_LENGTH samples.
// Assumes: SAMPLE_PERIOD >= 2, RUN_LENGTH >= 2; synchronous active-low reset.
module switch_debouncer
    import deb_pkg::*;
#(
    parameter int unsigned SAMPLE_PERIOD = 50000,
    parameter int unsigned RUN_LENGTH    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int unsigned SYNC_STAGES = 2;

    logic                  synced;
    logic                  sample_tick;
    logic [RUN_LENGTH-1:0] history;
    hist_state_e           hstate;

    deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    deb_tick_gen #(.PERIOD(SAMPLE_PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick)
    );

    deb_history #(.DEPTH(RUN_LENGTH)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sample_tick),
        .sample (synced),
        .hist   (history),
        .state  (hstate)
    );

    // Purpose: follow a unanimous history and hold the output when it is mixed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_out <= 1'b0;
        end else begin
            case (hstate)
                HIST_HIGH: clean_out <= 1'b1;
                HIST_LOW:  clean_out <= 1'b0;
                default:   clean_out <= clean_out;
            endcase
        end
    end
endmodule

// File: rtl/deb_checker.sv
// Module: deb_checker
// Property checks for switch_debouncer, attached to it with bind.
// Assumes: the same parameters as the checked instance.
module deb_checker
    import deb_pkg::*;
#(
    parameter int unsigned SAMPLE_PERIOD = 50000,
    parameter int unsigned RUN_LENGTH    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic [RUN_LENGTH-1:0] hist,
    input logic                  clean_out
);
    localparam int unsigned CW = cnt_width(SAMPLE_PERIOD);

    logic [CW-1:0] gap;

    // Purpose: count the cycles since the last strobe, independently of the generator.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) gap <= '0;
        else                gap <= gap + 1'b1;
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == CW'(SAMPLE_PERIOD - 1)));

    assert_hist_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(hist));

    assert_rise_unanimous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clean_out) |-> (&hist));

    assert_fall_unanimous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clean_out) |-> (~|hist));

    assert_mixed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((hist != '0) && (hist != '1)) |=> $stable(clean_out));
endmodule

bind switch_debouncer deb_checker #(
    .SAMPLE_PERIOD (SAMPLE_PERIOD),
    .RUN_LENGTH    (RUN_LENGTH)
) u_deb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .hist      (history),
    .clean_out (clean_out)
);

// File: tb/switch_debouncer_bench.sv
module switch_debouncer_bench;
    localparam int P = 4;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_in = 1'b0;
    logic clean_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    switch_debouncer #(.SAMPLE_PERIOD(P), .RUN_LENGTH(N)) u_switch_debouncer (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (raw_in),
        .clean_out (clean_out)
    );

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: clean_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Output must equal exp at every one of the next n sample points.
    task automatic hold_watch(input int n, input logic exp, input string req);
        logic bad = 1'b0;
        logic seen = exp;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clean_out !== exp && !bad) begin
                bad = 1'b1;
                seen = clean_out;
            end
        end
        check(!bad, req, seen, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; raw_in = 1'b0;
        cycles(3);
        check(clean_out === 1'b0, "R7 reset state", clean_out, 1'b0);
        rst_n = 1'b1;
        hold_watch(3 * P, 1'b0, "R7 stays low after release");
    endtask

    // High before and after release: the output must rise on edge N*P+1 exactly.
    task automatic t_exact_timing;
        rst_n = 1'b0; raw_in = 1'b1;
        cycles(3);
        rst_n = 1'b1;
        cycles(N * P);
        check(clean_out === 1'b0, "R2 R3 not before edge N*P+1", clean_out, 1'b0);
        cycles(1);
        check(clean_out === 1'b1, "R2 R3 rise on edge N*P+1", clean_out, 1'b1);
    endtask

    task automatic t_low_burst;
        raw_in = 1'b0;
        hold_watch((N - 2) * P, 1'b1, "R5 low burst during");
        raw_in = 1'b1;
        hold_watch((N + 2) * P, 1'b1, "R5 low burst ignored");
    endtask

    task automatic t_fall;
        raw_in = 1'b0;
        hold_watch((N - 1) * P, 1'b1, "R1 fall not early");
        cycles(2 * P + 3);
        check(clean_out === 1'b0, "R4 R6 steady low reached", clean_out, 1'b0);
    endtask

    task automatic t_high_burst;
        raw_in = 1'b1;
        hold_watch((N - 2) * P, 1'b0, "R5 high burst during");
        raw_in = 1'b0;
        hold_watch((N + 2) * P, 1'b0, "R5 high burst ignored");
    endtask

    // Pattern of length 3 against a sample interval of 4: samples never all agree.
    task automatic t_pattern;
        logic bad = 1'b0;
        for (int r = 0; r < 30; r++) begin
            for (int k = 0; k < 3; k++) begin
                raw_in = (k != 2);
                @(negedge clk);
                if (clean_out !== 1'b0) bad = 1'b1;
            end
        end
        raw_in = 1'b0;
        check(!bad, "R5 changing pattern holds", bad, 1'b0);
        hold_watch((N + 2) * P, 1'b0, "R5 after pattern");
    endtask

    task automatic t_rise;
        raw_in = 1'b1;
        hold_watch((N - 1) * P, 1'b0, "R1 rise not early");
        cycles(2 * P + 3);
        check(clean_out === 1'b1, "R4 R6 steady high reached", clean_out, 1'b1);
    endtask

    task automatic t_reset_mid;
        rst_n = 1'b0;
        cycles(1);
        check(clean_out === 1'b0, "R7 reset while high", clean_out, 1'b0);
        rst_n = 1'b1;
        hold_watch((N - 1) * P, 1'b0, "R7 history cleared");
    endtask

    initial begin
        cycles(1);
        t_reset();
        t_exact_timing();
        t_low_burst();
        t_fall();
        t_high_burst();
        t_pattern();
        t_rise();
        t_reset_mid();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule